// File: doc/BRIEF.md
# APB Control/Status Register Slave with Registered Readback

This block is a 32-bit APB completer holding a small bank of control, status and scratch data registers. Every register takes a full 32-bit word at a word-aligned offset. The block produces one write enable per register. It captures the read multiplexer output into a flop during the setup phase of a read, so read data reaches the bus from a register and not from a deep combinational path. Outside a read access, the read data output is driven to zero. This lets the outputs of several slaves on one segment be merged with a plain OR.

The peripheral's functional logic is represented by one pulse input per event. A pulse sets a sticky status bit. Software clears that bit by writing a one to it. An enable mask in the control register selects which status bits drive a level-sensitive interrupt output. Reading a register never changes any state, so a debugger can inspect the map while the system runs.

Register map (word offsets; offset bits [1:0] are not decoded): 0x0 control (interrupt enable mask in bits [3:0], other bits read zero), 0x4 event status (bits [3:0], write-one-to-clear, other bits read zero), 0x8 data word A, 0xC data word B. Every other offset is unmapped.

Top module: `apbcsr_slave`

## Requirements
- R1: Registers are selected by PADDR[11:2] only; the two low address bits are ignored on both reads and writes.
- R2: A read from an unmapped word offset returns zero, and a write to an unmapped offset changes no mapped register.
- R3: The data words at 0x8 and 0xC store all 32 written bits. The control register at 0x0 stores bits [3:0] and reads all higher bits as zero.
- R4: A register is written only in the access phase (PSEL, PENABLE and PWRITE all high, address matching). A setup cycle that is not followed by an access changes nothing.
- R5: PRDATA is all zeros in every cycle that is not the access phase of a read.
- R6: In the access cycle of a read, PRDATA holds the register value present during the setup cycle, with no wait state: PREADY is always high and PSLVERR always low.
- R7: A pulse on event input bit i sets status bit i, and the bit stays set until it is cleared.
- R8: Writing 1 to a status bit clears it, and writing 0 to it leaves it unchanged.
- R9: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R10: Reads have no side effects: reading any register, the status register included, leaves all register contents unchanged.
- R11: The interrupt output is a level that is high exactly while some status bit is set whose control enable bit is also set.
- R12: While PRESETn is low at a clock edge, all registers clear to zero, and after reset the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Active-low reset, sampled on the clock edge |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase indicator |
| pwrite | input | 1 | 1 = write transfer, 0 = read transfer |
| paddr | input | 12 | Byte address; bits [1:0] ignored |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data, zero outside read access |
| pready | output | 1 | Always high, no wait states |
| pslverr | output | 1 | Always low |
| evt | input | 4 | Event pulses that set status bits |
| irq | output | 1 | Level interrupt: enabled status pending |

## Verification
The bench targets the status bit hit by a clearing write and an event in the same cycle. A design that gives priority to the clear would lose that event. It writes zeros across set status bits, which catches a design that clears on any write instead of only on written ones. It probes nonzero low address bits, unmapped offsets and aborted setup-only cycles, which would expose a decoder that used the full address or wrote in the setup phase. It repeats status reads to show that a design that clears on read fails, and it watches PRDATA in setup and idle cycles, where a design that skipped the gating would leak stale data onto the OR-merged bus.

// File: rtl/apbcsr_pkg.sv
package apbcsr_pkg;

    // Default geometry of the register bank
    localparam int ADDR_W_DEF   = 12;
    localparam int DATA_W_DEF   = 32;
    localparam int NUM_EVT_DEF  = 4;
    localparam int NUM_DATA_DEF = 2;

    // Word slots of the fixed registers; data words follow them
    localparam int SLOT_CTRL = 0;
    localparam int SLOT_STAT = 1;
    localparam int SLOT_DATA = 2;

    // Phase classification of the current bus cycle
    typedef struct packed {
        logic wr_access;   // write, access phase
        logic rd_setup;    // read, setup phase
        logic rd_access;   // read, access phase
    } bus_phase_t;

    function automatic bus_phase_t classify(input logic sel, input logic en, input logic wr);
        bus_phase_t p;
        p.wr_access = sel & en & wr;
        p.rd_setup  = sel & ~en & ~wr;
        p.rd_access = sel & en & ~wr;
        return p;
    endfunction

    // Sticky status update: clear by ones written, events have priority
    function automatic logic [31:0] sticky_next(input logic [31:0] cur,
                                                input logic [31:0] clr,
                                                input logic [31:0] set);
        return (cur & ~clr) | set;
    endfunction

endpackage

// File: rtl/apbcsr_decode.sv
module apbcsr_decode
    import apbcsr_pkg::*;
#(
    parameter int IDX_W    = 10,
    parameter int NUM_REGS = 4
) (
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [IDX_W-1:0]    word_idx,
    output logic [NUM_REGS-1:0] sel_oh,
    output logic [NUM_REGS-1:0] wr_en,
    output logic                rd_setup,
    output logic                rd_access
);

    bus_phase_t phase;

    always_comb phase = classify(psel, penable, pwrite);

    assign rd_setup  = phase.rd_setup;
    assign rd_access = phase.rd_access;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_slot
        assign sel_oh[r] = (word_idx == IDX_W'(r));
        assign wr_en[r]  = phase.wr_access & sel_oh[r];
    end

endmodule

// File: rtl/apbcsr_rwreg.sv
module apbcsr_rwreg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_en) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/apbcsr_status.sv
module apbcsr_status
    import apbcsr_pkg::*;
#(
    parameter int NUM_EVT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [NUM_EVT-1:0] wdata,
    input  logic [NUM_EVT-1:0] evt,
    output logic [NUM_EVT-1:0] q
);

    logic [NUM_EVT-1:0] clr_mask;
    logic [31:0]        nxt_full;

    assign clr_mask = wr_en ? wdata : '0;

    always_comb nxt_full = sticky_next(32'(q), 32'(clr_mask), 32'(evt));

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= nxt_full[NUM_EVT-1:0];
        end
    end

endmodule

// File: rtl/apbcsr_rdpipe.sv
module apbcsr_rdpipe #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             rd_setup,
    input  logic                             rd_access,
    input  logic [NUM_REGS-1:0]              sel_oh,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  reg_vals,
    output logic [DATA_W-1:0]                rdata_q,
    output logic [DATA_W-1:0]                prdata
);

    logic [DATA_W-1:0] mux_out;

    // One-hot AND-OR select; no slot selected yields zero
    always_comb begin
        mux_out = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            mux_out = mux_out | (reg_vals[r] & {DATA_W{sel_oh[r]}});
        end
    end

    // Capture only in a read setup cycle, otherwise hold
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_setup) begin
            rdata_q <= mux_out;
        end
    end

    assign prdata = rdata_q & {DATA_W{rd_access}};

endmodule

// File: rtl/apbcsr_slave.sv
module apbcsr_slave
    import apbcsr_pkg::*;
#(
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int DATA_W   = DATA_W_DEF,
    parameter int NUM_EVT  = NUM_EVT_DEF,
    parameter int NUM_DATA = NUM_DATA_DEF
) (
    input  logic               pclk,
    input  logic               presetn,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [DATA_W-1:0]  pwdata,
    output logic [DATA_W-1:0]  prdata,
    output logic               pready,
    output logic               pslverr,
    input  logic [NUM_EVT-1:0] evt,
    output logic               irq
);

    localparam int IDX_W    = ADDR_W - 2;
    localparam int NUM_REGS = SLOT_DATA + NUM_DATA;

    logic                             rst;
    logic [NUM_REGS-1:0]              sel_oh;
    logic [NUM_REGS-1:0]              wr_en;
    logic                             rd_setup;
    logic                             rd_access;
    logic [NUM_EVT-1:0]               ctrl_q;
    logic [NUM_EVT-1:0]               stat_q;
    logic [NUM_DATA-1:0][DATA_W-1:0]  data_q;
    logic [NUM_REGS-1:0][DATA_W-1:0]  reg_vals;
    logic [DATA_W-1:0]                rdata_q;
    logic                             unused_lo;

    assign rst       = ~presetn;
    assign unused_lo = ^paddr[1:0];

    apbcsr_decode #(
        .IDX_W    (IDX_W),
        .NUM_REGS (NUM_REGS)
    ) u_decode (
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .word_idx  (paddr[ADDR_W-1:2]),
        .sel_oh    (sel_oh),
        .wr_en     (wr_en),
        .rd_setup  (rd_setup),
        .rd_access (rd_access)
    );

    apbcsr_rwreg #(.W(NUM_EVT)) u_ctrl (
        .clk   (pclk),
        .rst   (rst),
        .wr_en (wr_en[SLOT_CTRL]),
        .wdata (pwdata[NUM_EVT-1:0]),
        .q     (ctrl_q)
    );

    apbcsr_status #(.NUM_EVT(NUM_EVT)) u_status (
        .clk   (pclk),
        .rst   (rst),
        .wr_en (wr_en[SLOT_STAT]),
        .wdata (pwdata[NUM_EVT-1:0]),
        .evt   (evt),
        .q     (stat_q)
    );

    for (genvar d = 0; d < NUM_DATA; d++) begin : g_data
        apbcsr_rwreg #(.W(DATA_W)) u_word (
            .clk   (pclk),
            .rst   (rst),
            .wr_en (wr_en[SLOT_DATA + d]),
            .wdata (pwdata),
            .q     (data_q[d])
        );
        assign reg_vals[SLOT_DATA + d] = data_q[d];
    end

    assign reg_vals[SLOT_CTRL] = DATA_W'(ctrl_q);
    assign reg_vals[SLOT_STAT] = DATA_W'(stat_q);

    apbcsr_rdpipe #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_rdpipe (
        .clk       (pclk),
        .rst       (rst),
        .rd_setup  (rd_setup),
        .rd_access (rd_access),
        .sel_oh    (sel_oh),
        .reg_vals  (reg_vals),
        .rdata_q   (rdata_q),
        .prdata    (prdata)
    );

    assign irq     = |(stat_q & ctrl_q);
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

endmodule

// File: rtl/apbcsr_checker.sv
module apbcsr_checker #(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int NUM_EVT = 4
) (
    input logic               clk,
    input logic               presetn,
    input logic               psel,
    input logic               penable,
    input logic               pwrite,
    input logic [ADDR_W-1:0]  paddr,
    input logic [DATA_W-1:0]  pwdata,
    input logic [DATA_W-1:0]  prdata,
    input logic               pready,
    input logic               pslverr,
    input logic [NUM_EVT-1:0] evt,
    input logic               irq,
    input logic [NUM_EVT-1:0] stat_q,
    input logic [NUM_EVT-1:0] ctrl_q,
    input logic [DATA_W-1:0]  rdata_q
);

    logic               rd_acc;
    logic               rd_set;
    logic [NUM_EVT-1:0] clr_seen;

    assign rd_acc   = psel && penable && !pwrite;
    assign rd_set   = psel && !penable && !pwrite;
    assign clr_seen = (psel && penable && pwrite && (paddr[ADDR_W-1:2] == 1))
                      ? pwdata[NUM_EVT-1:0] : '0;

    AST_PRDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!presetn)
        !rd_acc |-> (prdata == '0)); // R5

    AST_NO_WAIT_NO_ERR: assert property (@(posedge clk) disable iff (!presetn)
        pready && !pslverr); // R6

    AST_PIPE_HOLDS: assert property (@(posedge clk) disable iff (!presetn)
        !rd_set |=> $stable(rdata_q)); // R6

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!presetn)
        (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt))); // R9

    AST_CLEAR_ONLY_BY_ONE: assert property (@(posedge clk) disable iff (!presetn)
        (stat_q != '0) |=> ((~stat_q & $past(stat_q) & ~$past(clr_seen)) == '0)); // R8

    AST_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (!presetn)
        (rd_acc && evt == '0) |=> ($stable(stat_q) && $stable(ctrl_q))); // R10

    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!presetn)
        irq |-> ((stat_q != '0) && (ctrl_q != '0))); // R11

endmodule

bind apbcsr_slave apbcsr_checker #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NUM_EVT (NUM_EVT)
) u_chk (
    .clk     (pclk),
    .presetn (presetn),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .pready  (pready),
    .pslverr (pslverr),
    .evt     (evt),
    .irq     (irq),
    .stat_q  (stat_q),
    .ctrl_q  (ctrl_q),
    .rdata_q (rdata_q)
);

// File: tb/tb_apbcsr_slave.sv
`timescale 1ns/1ps
module tb_apbcsr_slave;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic [3:0]  evt = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    // Bench model of register contents
    logic [3:0]  m_ctrl = '0;
    logic [3:0]  m_stat = '0;
    logic [31:0] m_d0 = '0;
    logic [31:0] m_d1 = '0;

    always #2.5 pclk = ~pclk;

    apbcsr_slave dut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .evt(evt), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        case (a[11:2])
            10'd0:   return {28'd0, m_ctrl};
            10'd1:   return {28'd0, m_stat};
            10'd2:   return m_d0;
            10'd3:   return m_d1;
            default: return 32'd0;
        endcase
    endfunction

    function automatic void model_write(input logic [11:0] a, input logic [31:0] d,
                                        input logic [3:0] e);
        logic [3:0] clr;
        clr = (a[11:2] == 10'd1) ? d[3:0] : 4'd0;
        case (a[11:2])
            10'd0:   m_ctrl = d[3:0];
            10'd2:   m_d0 = d;
            10'd3:   m_d1 = d;
            default: ;
        endcase
        m_stat = (m_stat & ~clr) | e;
    endfunction

    // Write; e is driven during the access cycle
    task automatic apb_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] e);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1'b1; evt = e;
        check("R6 pready/pslverr", {30'd0, pready, pslverr}, 32'd2);
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; evt = '0;
        model_write(a, d, e);
    endtask

    task automatic apb_read(input logic [11:0] a, input string tag);
        logic [31:0] exp;
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        exp = exp_read(a);
        #1 check("R5 prdata zero in setup", prdata, 32'd0);
        @(negedge pclk);
        penable = 1'b1;
        #1 check(tag, prdata, exp);
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
        #1 check("R5 prdata zero when idle", prdata, 32'd0);
    endtask

    task automatic pulse(input logic [3:0] e);
        @(negedge pclk);
        evt = e;
        @(negedge pclk);
        evt = '0;
        m_stat = m_stat | e;
    endtask

    task automatic check_irq(input string tag);
        #1 check(tag, {31'd0, irq}, {31'd0, |(m_stat & m_ctrl)});
    endtask

    initial begin
        repeat (100000) @(posedge pclk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge pclk);
        presetn = 1'b1;

        // R12 reset state
        check("R12 irq after reset", {31'd0, irq}, 32'd0);
        apb_read(12'h000, "R12 ctrl reset");
        apb_read(12'h004, "R12 stat reset");
        apb_read(12'h008, "R12 data A reset");
        apb_read(12'h00C, "R12 data B reset");

        // R3 full-width data and masked control
        apb_write(12'h008, 32'hDEADBEEF, 4'd0);
        apb_write(12'h00C, 32'h12345678, 4'd0);
        apb_write(12'h000, 32'hFFFF_FFF5, 4'd0);
        apb_read(12'h008, "R3 data A");
        apb_read(12'h00C, "R3 data B");
        apb_read(12'h000, "R3 ctrl upper bits zero");

        // R1 low address bits ignored
        apb_write(12'h00B, 32'hA5A5_0001, 4'd0);
        apb_read(12'h00A, "R1 data A via offset+2");
        apb_read(12'h00F, "R1 data B via offset+3");

        // R2 unmapped
        apb_write(12'h010, 32'hFFFF_FFFF, 4'd0);
        apb_write(12'hFFC, 32'hFFFF_FFFF, 4'd0);
        apb_read(12'h010, "R2 unmapped read zero");
        apb_read(12'h008, "R2 data A untouched");
        apb_read(12'h000, "R2 ctrl untouched");

        // R4 setup-only cycle does not write
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'h008; pwdata = 32'h0BAD_0BAD;
        @(negedge pclk);
        psel = 1'b0;
        apb_read(12'h008, "R4 aborted write ignored");

        // R7 events set sticky bits, R11 irq level
        pulse(4'b0011);
        check_irq("R11 irq after events");
        repeat (3) @(negedge pclk);
        apb_read(12'h004, "R7 status sticky");
        check_irq("R11 irq held as level");

        // R10 repeated reads keep status
        apb_read(12'h004, "R10 status after second read");
        apb_read(12'h004, "R10 status after third read");

        // R8 writing zeros keeps, writing one clears
        apb_write(12'h004, 32'hFFFF_FFF0, 4'd0);
        apb_read(12'h004, "R8 zero write keeps");
        apb_write(12'h004, 32'h0000_0001, 4'd0);
        apb_read(12'h004, "R8 one write clears bit0");
        check_irq("R11 irq after partial clear");

        // R9 set wins over clear
        apb_write(12'h004, 32'h0000_0002, 4'b0010);
        apb_read(12'h004, "R9 set wins same cycle");

        // R11 mask off gives low irq
        apb_write(12'h000, 32'h0, 4'd0);
        check_irq("R11 irq masked");
        apb_write(12'h000, 32'h2, 4'd0);
        check_irq("R11 irq unmasked");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [11:0] a;
            op = int'($urandom % 4);
            a = {$urandom % 6 == 5 ? 10'h3FF : 10'($urandom % 5), 2'($urandom)};
            case (op)
                0: apb_write(a, $urandom, 4'd0);
                1: apb_write(a, $urandom, 4'($urandom));
                2: apb_read(a, "R6 random read");
                default: pulse(4'($urandom));
            endcase
            check_irq("R11 random irq");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule